// File: doc/BRIEF.md
# SPI Serial Clock Divider with Linear and Binary Stages

This block derives the serial clock timing for an SPI master from the module clock. Two three-bit fields set the division. A linear stage multiplies the division by its field value plus one. A binary stage doubles the division for each step of its field. The overall divisor of the module clock is `(pre_sel + 1) * 2^(rate_sel + 1)`. This product reaches ratios that are not powers of two, such as 6 and 10, as well as every power of two from 2 to 256.

The block emits a one-cycle `tick` at every boundary between two serial-clock half-periods. It also emits `sck_phase`, which is the divided clock level itself and has a 50% duty cycle. The shift engine raises `en` for the duration of a transfer. While `en` is low, the divider stays at rest and copies the two fields on every clock. When `en` rises, the divider starts from zero using the fields copied at the last edge before it rose. The first tick therefore lands at a fixed cycle, and a setting change cannot disturb a transfer in progress.

Top module: `spi_baud_div`

## Requirements
- R1: With the divider enabled, `tick` is high for exactly one cycle in every H cycles, where H = (`pre_sel`+1) * 2^`rate_sel` is half of the full divisor (`pre_sel` and `rate_sel` are each unsigned three-bit values).
- R2: With both fields zero the divisor is 2, so H = 1 and `tick` stays high in every enabled cycle.
- R3: Each step of `rate_sel` doubles the divisor. With `pre_sel`=0, the value `rate_sel`=1 gives divide by 4 (tick every 2 cycles) and `rate_sel`=2 gives divide by 8 (tick every 4 cycles).
- R4: The linear stage multiplies the divisor by `pre_sel`+1. With `rate_sel`=0, the value `pre_sel`=2 gives divide by 6 (tick every 3 cycles) and `pre_sel`=4 gives divide by 10 (tick every 5 cycles).
- R5: `sck_phase` is 0 when the divider starts. It inverts at the clock edge that ends each tick cycle and holds its value at every other enabled edge. It is therefore high in cycles H..2H-1 of each 2H-cycle period.
- R6: Count cycles from 0, where cycle 0 is the first cycle in which `en` is high. The first tick then occurs in cycle H-1.
- R7: The fields are captured at every clock edge where `en` is low. Changes to them while `en` is high have no effect on tick spacing or phase.
- R8: While `en` is low, `tick` is low. The clock edge after `en` falls clears `sck_phase` to 0 and returns the count to zero.
- R9: After reset, `tick` and `sck_phase` are both 0.
- R10: The largest setting (`pre_sel`=7, `rate_sel`=7) gives divide by 2048, with one tick every 1024 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run the divider; low holds it at rest and captures the fields |
| pre_sel | input | 3 | Linear stage field, factor = value + 1 |
| rate_sel | input | 3 | Binary stage field, factor = 2^(value + 1) |
| tick | output | 1 | One-cycle pulse at each serial-clock half-period boundary |
| sck_phase | output | 1 | Divided clock level, 50% duty |

## Verification
`tick` is combinational from the count and `en`. It is therefore due in the same cycle as the count reaching H-1, which is cycle H-1 after `en` rises with no extra register stage. `sck_phase` is registered and changes one edge after a tick, and it clears one edge after `en` falls. The bench drives inputs just after each falling edge. It samples 1 ns later and compares every cycle against `i mod H` and `(i / H) mod 2`, where `i` is the cycle index computed from the fields the bench applied before raising `en`. Changes to the fields made mid-run are deliberately left out of that expectation.

// File: rtl/spi_baud_div.sv
module spi_baud_div #(
  parameter int PRE_W = 3,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] pre_sel,
  input  logic [SEL_W-1:0] rate_sel,
  output logic             tick,
  output logic             sck_phase
);
  localparam int MAX_PRE  = 1 << PRE_W;
  localparam int MAX_HALF = MAX_PRE << ((1 << SEL_W) - 1);
  localparam int CNT_W    = $clog2(MAX_HALF);
  localparam int HALF_W   = CNT_W + 1;

  logic [PRE_W-1:0]  pre_q;
  logic [SEL_W-1:0]  sel_q;
  logic [CNT_W-1:0]  cnt;
  logic [HALF_W-1:0] half;
  logic              last;

  assign half = (HALF_W'(pre_q) + HALF_W'(1)) << sel_q;
  assign last = (HALF_W'(cnt) + HALF_W'(1)) == half;
  assign tick = en & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q     <= '0;
      sel_q     <= '0;
      cnt       <= '0;
      sck_phase <= 1'b0;
    end else if (!en) begin
      pre_q     <= pre_sel;
      sel_q     <= rate_sel;
      cnt       <= '0;
      sck_phase <= 1'b0;
    end else if (last) begin
      cnt       <= '0;
      sck_phase <= ~sck_phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_baud_div_chk.sv
module spi_baud_div_chk #(
  parameter int PRE_W = 3,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [PRE_W-1:0] pre_sel,
  input logic [SEL_W-1:0] rate_sel,
  input logic             tick,
  input logic             sck_phase
);
  localparam int GAP_W = PRE_W + (1 << SEL_W) + 1;

  logic [GAP_W-1:0] gap, first_gap;
  logic             have_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap        <= GAP_W'(1);
      first_gap  <= '0;
      have_first <= 1'b0;
    end else if (!en) begin
      gap        <= GAP_W'(1);
      have_first <= 1'b0;
    end else if (tick) begin
      if (!have_first) first_gap <= gap;
      have_first <= 1'b1;
      gap        <= GAP_W'(1);
    end else begin
      gap <= gap + 1'b1;
    end
  end

  a_r1_even_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && have_first) |-> (gap == first_gap));

  a_r2_div2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(!en) && $past(pre_sel) == '0 && $past(rate_sel) == '0) |-> tick);

  a_r5_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (sck_phase != $past(sck_phase)));

  a_r5_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(sck_phase));

  a_r8_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sck_phase);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick);
endmodule

bind spi_baud_div spi_baud_div_chk #(.PRE_W(PRE_W), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .pre_sel(pre_sel), .rate_sel(rate_sel),
  .tick(tick), .sck_phase(sck_phase)
);

// File: tb/spi_baud_div_tb_top.sv
`timescale 1ns/1ps
module spi_baud_div_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [2:0] pre_sel = '0;
  logic [2:0] rate_sel = '0;
  logic       tick, sck_phase;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  spi_baud_div dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .pre_sel(pre_sel), .rate_sel(rate_sel),
    .tick(tick), .sck_phase(sck_phase)
  );

  function automatic int half_of(input int p, input int s);
    return (p + 1) << s;
  endfunction

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic run_cfg(input int p, input int s, input int n, input bit scramble, input string req);
    int h;
    h = half_of(p, s);
    @(negedge clk);
    en = 1'b0; pre_sel = 3'(p); rate_sel = 3'(s);
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
    for (int i = 0; i < n; i++) begin
      #1;
      check(tick, (i % h) == h - 1, req, "tick");
      check(sck_phase, ((i / h) % 2) == 1, "R5", "phase");
      if (scramble && i == h / 2) begin
        pre_sel  = 3'($urandom % 8);
        rate_sel = 3'($urandom % 8);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check(tick, 1'b0, "R9", "tick in reset");
    check(sck_phase, 1'b0, "R9", "phase in reset");
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(tick, 1'b0, "R9", "tick after reset");
    check(sck_phase, 1'b0, "R9", "phase after reset");

    run_cfg(0, 0, 8, 1'b0, "R2");
    run_cfg(0, 1, 10, 1'b0, "R3");
    run_cfg(0, 2, 16, 1'b0, "R3");
    run_cfg(2, 0, 12, 1'b0, "R4");
    run_cfg(4, 0, 20, 1'b0, "R4");
    run_cfg(3, 2, 64, 1'b0, "R6");
    run_cfg(7, 7, 2100, 1'b0, "R10");
    run_cfg(1, 1, 24, 1'b1, "R7");
    run_cfg(6, 3, 200, 1'b1, "R7");

    run_cfg(1, 0, 4, 1'b0, "R8");
    en = 1'b0;
    #1;
    check(tick, 1'b0, "R8", "tick when disabled");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check(tick, 1'b0, "R8", "tick while idle");
      check(sck_phase, 1'b0, "R8", "phase while idle");
    end
    run_cfg(1, 0, 6, 1'b0, "R6");

    for (int r = 0; r < 24; r++) begin
      int p, s;
      p = int'($urandom % 8);
      s = int'($urandom % 6);
      run_cfg(p, s, 3 * half_of(p, s) + 2, r[0], "R1");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule